// File: doc/BRIEF.md
# Branching Instruction Fetch Unit

This block owns the program counter of a single-cycle processor core. Every cycle it presents the current PC to a combinational instruction memory, hands the returned 32-bit instruction word straight back to the core, and on the next rising clock edge loads the address of the following instruction. Fetching works the same way for every instruction. The only difference between instructions is which next address is chosen.

The decoder drives a one-bit branch request, meaning "this is a conditional branch" as opposed to "advance by one word". The fetch unit combines this request with the ALU zero flag itself. When both are high, the branch is taken. The 16-bit immediate is then sign-extended, scaled by four (two zero bits appended) and added to PC + 4. In every other case the PC moves on to PC + 4. A synchronous reset loads a start address, which is zero by default.

Inside the block, the next-address choice is an enumerated selector with two named values. `NPC_SEQ` is the sequential step. `NPC_TAKEN` is the taken branch. In any cycle where reset is low, the PC register moves from its current value to the address that the selector picks. In a cycle where reset is high, it loads the start address, whatever the selector picks.

Top module: `fetch_pc_unit`

## Requirements
- R1: On a rising edge with `rst` high, the PC becomes `RESET_ADDR` (default 0). This holds even when a taken branch is requested in the same cycle.
- R2: `imem_addr` always equals the current PC, and `instr` equals `imem_rdata` in the same cycle, with no register in between.
- R3: With `br_sel` = 0 and `alu_zero` = 0, the PC becomes PC + 4 on the next edge.
- R4: With `br_sel` = 1 and `alu_zero` = 0 (a branch that is not taken), the PC becomes PC + 4 and the immediate has no effect.
- R5: With `br_sel` = 1 and `alu_zero` = 1, the PC becomes PC + 4 + (sign-extended `imm16` shifted left by 2).
- R6: Bit 15 of `imm16` is the sign bit. Negative offsets move the PC backwards, and `imm16` = 16'hFFFF makes the target equal to the current PC.
- R7: The two low bits of the PC are always zero.
- R8: With `alu_zero` = 1 but `br_sel` = 0, the PC becomes PC + 4. The zero flag alone never redirects fetch.
- R9: Address arithmetic wraps modulo 2^32 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous reset; loads the start address |
| br_sel | input | 1 | Branch request from the decoder (1 = branch, 0 = +4) |
| alu_zero | input | 1 | ALU zero flag for the current instruction |
| imm16 | input | 16 | Branch offset in words, two's complement |
| imem_rdata | input | 32 | Word returned by the instruction memory |
| imem_addr | output | 32 | Current PC, sent to the instruction memory |
| instr | output | 32 | Fetched instruction, passed to the core |

## Verification
Two functions can fall in the same cycle: reset and a taken branch. The bench provokes this by holding `rst` high while `br_sel` and `alu_zero` are both high and a non-zero offset is applied. It judges the result by requiring the PC to read the start address after that edge instead of the branch target. The bench also drives a zero flag without a branch request, and a branch request without a zero flag. In both cases it expects the plain +4 step. An offset of -1 is used to show that the branch target is measured from PC + 4.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic {
        NPC_SEQ   = 1'b0,
        NPC_TAKEN = 1'b1
    } npc_src_e;

endpackage

// File: rtl/fetch_next_addr.sv
module fetch_next_addr #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned INSTR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [IMM_W-1:0]  offset,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] tgt_addr
);
    localparam int unsigned STEP  = INSTR_W / 8;
    localparam int unsigned SHIFT = $clog2(STEP);
    localparam int unsigned SEXT  = ADDR_W - IMM_W - SHIFT;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] offset_bytes;

    // Sign-extend the word offset and scale it to bytes.
    always_comb begin
        offset_bytes = {{SEXT{offset[IMM_W-1]}}, offset, {SHIFT{1'b0}}};
        seq_addr     = pc_cur + STEP_V;
        tgt_addr     = seq_addr + offset_bytes;
    end
endmodule

// File: rtl/fetch_sel.sv
module fetch_sel
    import fetch_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              br_req,
    input  logic              zero_flag,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] tgt_addr,
    output npc_src_e          src,
    output logic [ADDR_W-1:0] npc
);
    // The branch request is qualified here by the zero flag.
    always_comb begin
        src = (br_req && zero_flag) ? NPC_TAKEN : NPC_SEQ;
    end

    always_comb begin
        unique case (src)
            NPC_SEQ:   npc = seq_addr;
            NPC_TAKEN: npc = tgt_addr;
        endcase
    end
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
    parameter int unsigned          ADDR_W     = 32,
    parameter int unsigned          ALIGN_BITS = 2,
    parameter logic [ADDR_W-1:0]    RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc_d,
    output logic [ADDR_W-1:0] pc_q
);
    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_ADDR;
        else     pc_q <= pc_d;
    end

    // R1
    reset_load_chk: assert property (@(posedge clk)
        rst |=> (pc_q == RESET_ADDR));

    // R7
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        pc_q[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       IMM_W      = 16,
    parameter int unsigned       INSTR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               br_sel,
    input  logic               alu_zero,
    input  logic [IMM_W-1:0]   imm16,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [ADDR_W-1:0]  imem_addr,
    output logic [INSTR_W-1:0] instr
);
    localparam int unsigned STEP  = INSTR_W / 8;
    localparam int unsigned SHIFT = $clog2(STEP);
    localparam int unsigned SEXT  = ADDR_W - IMM_W - SHIFT;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] tgt_addr;
    logic [ADDR_W-1:0] npc;
    npc_src_e          src;

    fetch_next_addr #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .INSTR_W(INSTR_W)
    ) u_next (
        .pc_cur  (pc),
        .offset  (imm16),
        .seq_addr(seq_addr),
        .tgt_addr(tgt_addr)
    );

    fetch_sel #(
        .ADDR_W(ADDR_W)
    ) u_sel (
        .br_req   (br_sel),
        .zero_flag(alu_zero),
        .seq_addr (seq_addr),
        .tgt_addr (tgt_addr),
        .src      (src),
        .npc      (npc)
    );

    fetch_pc_reg #(
        .ADDR_W    (ADDR_W),
        .ALIGN_BITS(SHIFT),
        .RESET_ADDR(RESET_ADDR)
    ) u_pc (
        .clk (clk),
        .rst (rst),
        .pc_d(npc),
        .pc_q(pc)
    );

    // The memory is combinational, so the fetched word passes straight through.
    always_comb begin
        imem_addr = pc;
        instr     = imem_rdata;
    end

    // R3 R4 R8
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(br_sel && alu_zero) |=> (pc == $past(pc) + STEP_V));

    // R5 R6
    taken_step_chk: assert property (@(posedge clk) disable iff (rst)
        (br_sel && alu_zero) |=> (pc == $past(pc) + STEP_V +
            {{SEXT{$past(imm16[IMM_W-1])}}, $past(imm16), {SHIFT{1'b0}}}));

    // R5
    taken_src_chk: assert property (@(posedge clk) disable iff (rst)
        (br_sel && alu_zero) |-> (src == NPC_TAKEN));
endmodule

// File: tb/sim_fetch_pc_unit.sv
module sim_fetch_pc_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        br_sel;
    logic        alu_zero;
    logic [15:0] imm16;
    logic [31:0] imem_rdata;
    logic [31:0] imem_addr;
    logic [31:0] instr;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_pc;

    always #4 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    assign imem_rdata = mem_word(imem_addr);

    fetch_pc_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .br_sel    (br_sel),
        .alu_zero  (alu_zero),
        .imm16     (imm16),
        .imem_rdata(imem_rdata),
        .imem_addr (imem_addr),
        .instr     (instr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs for one cycle at a falling edge; check at the next falling edge.
    task automatic step(input logic r, input logic b, input logic z,
                        input logic [15:0] im, input string req);
        rst = r; br_sel = b; alu_zero = z; imm16 = im;
        if (r)           exp_pc = 32'h0;
        else if (b && z) exp_pc = exp_pc + 32'd4 + {{14{im[15]}}, im, 2'b00};
        else             exp_pc = exp_pc + 32'd4;
        @(negedge clk);
        chk(req, imem_addr, exp_pc);
        chk("R2 instr", instr, mem_word(exp_pc));
        chk("R7 align", {30'b0, imem_addr[1:0]}, 32'h0);
    endtask

    task automatic t_reset();
        step(1'b1, 1'b0, 1'b0, 16'h0, "R1 reset");
        step(1'b1, 1'b0, 1'b0, 16'h0, "R1 reset hold");
    endtask

    task automatic t_sequential();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 16'h1234, "R3 seq");
    endtask

    task automatic t_zero_alone();
        step(1'b0, 1'b0, 1'b1, 16'h0010, "R8 zero only");
    endtask

    task automatic t_not_taken();
        step(1'b0, 1'b1, 1'b0, 16'h0040, "R4 not taken");
    endtask

    task automatic t_taken_fwd();
        step(1'b0, 1'b1, 1'b1, 16'h0010, "R5 taken fwd");
        step(1'b0, 1'b1, 1'b1, 16'h7FFF, "R5 taken max");
    endtask

    task automatic t_taken_back();
        step(1'b0, 1'b1, 1'b1, 16'hFFF0, "R6 taken back");
        step(1'b0, 1'b1, 1'b1, 16'hFFFF, "R6 self loop");
        step(1'b0, 1'b1, 1'b1, 16'hFFFF, "R6 self loop again");
    endtask

    task automatic t_wrap();
        step(1'b1, 1'b0, 1'b0, 16'h0, "R1 reset");
        step(1'b0, 1'b1, 1'b1, 16'h8000, "R9 wrap down");
        chk("R9 wrap down value", imem_addr, 32'hFFFE_0004);
        step(1'b0, 1'b1, 1'b1, 16'h7FFF, "R9 wrap up");
        chk("R9 wrap up value", imem_addr, 32'h0000_0004);
    endtask

    task automatic t_reset_vs_branch();
        step(1'b0, 1'b0, 1'b0, 16'h0, "R3 seq");
        step(1'b1, 1'b1, 1'b1, 16'h0100, "R1 reset beats branch");
        step(1'b0, 1'b0, 1'b0, 16'h0, "R3 seq after reset");
    endtask

    initial begin
        rst = 1'b1; br_sel = 1'b0; alu_zero = 1'b0; imm16 = 16'h0;
        exp_pc = 32'h0;
        @(negedge clk);
        t_reset();
        t_sequential();
        t_zero_alone();
        t_not_taken();
        t_taken_fwd();
        t_taken_back();
        t_wrap();
        t_reset_vs_branch();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule